// File: doc/BRIEF.md
# Flash Timing Clock Divider Register

This block is a byte-wide control register that sets the rate of the timing tick used by the flash program and erase logic. Software writes a divisor and a prescale select. The block then divides the bus clock by the divisor plus one. When the prescale select is set, it divides by eight more. The result is a one-cycle clock-enable strobe, `tick`. One period of this strobe is one program or erase timing pulse. The divided rate is meant to fall between 150 kHz and 200 kHz, which gives pulses of 5 to 6.7 us. For example, an 8 MHz bus with divisor 39 and no prescale gives 200 kHz, and so does a 1 MHz bus with divisor 4.

The register carries a read-only flag that records whether it has been written since reset. The first write sets this flag, whatever data that write carries. The flag drives `pe_enable`, so flash program and erase stay locked out until the divider has been configured. Every write restarts the prescale and divide counters, so a new setting starts on a clean period boundary.

Top module: `flash_tick_divider`

## Requirements
- R1: After reset, `rd_data` reads 0x00 and `pe_enable` is 0.
- R2: Register layout: bit 7 is the loaded flag, bit 6 is the prescale select and bits 5:0 are the divisor. Bits 6:0 read back exactly as last written. The value written to bit 7 has no effect on the register.
- R3: A write sets the loaded flag, even when bit 7 of the written data is 0. The flag stays set until the next reset.
- R4: `pe_enable` equals the loaded flag at all times.
- R5: With prescale 0 and divisor N, `tick` repeats every N+1 bus cycles.
- R6: With prescale 1 and divisor N, `tick` repeats every 8*(N+1) bus cycles.
- R7: A write restarts counting. The cycle after the write edge is cycle 0, and the first `tick` comes in cycle N, or in cycle 8*(N+1)-1 when prescale is 1.
- R8: With divisor 0 and prescale 0, including the state after reset, `tick` is high in every cycle.
- R9: Whenever its period exceeds one cycle, `tick` is exactly one bus cycle wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register contents: loaded flag, prescale select, divisor |
| tick | output | 1 | One-cycle timing enable at the divided rate |
| pe_enable | output | 1 | Permits flash program and erase operations |

## Verification
The bench writes data with bit 7 clear. A design that copied bit 7 from the bus would leave the flag low and keep program and erase locked. It also writes data with bit 7 set, which a design that stored bit 7 would echo back. Tick phase is measured from the write edge. This exposes an off-by-one in the terminal compare, which would stretch every period by one cycle. It also exposes a missing counter restart, which would put the first tick at a leftover phase. The bench rewrites the register in the middle of a count, and it runs the extremes: divisor 0 with and without prescale, and divisor 63 with prescale. A prescaler that ran at the wrong point, or ignored its select, would show up there as a wrong period.

// File: rtl/flash_tick_divider.sv
module flash_tick_divider #(
  parameter int DIV_W     = 6,
  parameter int PRE_RATIO = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DIV_W+1:0] wr_data,
  output logic [DIV_W+1:0] rd_data,
  output logic             tick,
  output logic             pe_enable
);
  localparam int PRE_W = (PRE_RATIO > 1) ? $clog2(PRE_RATIO) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_RATIO - 1);

  logic             loaded;
  logic             pre_sel;
  logic [DIV_W-1:0] div_val;
  logic [DIV_W-1:0] div_cnt;
  logic [PRE_W-1:0] pre_cnt;
  logic             pre_tick;
  logic             at_term;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loaded  <= 1'b0;
      pre_sel <= 1'b0;
      div_val <= '0;
    end else if (wr_en) begin
      loaded  <= 1'b1;
      pre_sel <= wr_data[DIV_W];
      div_val <= wr_data[DIV_W-1:0];
    end
  end

  assign pre_tick = !pre_sel || (pre_cnt == PRE_LAST);
  assign at_term  = (div_cnt == div_val);

  always_ff @(posedge clk) begin
    if (!rst_n || wr_en) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else begin
      if (pre_sel)
        pre_cnt <= (pre_cnt == PRE_LAST) ? '0 : pre_cnt + PRE_W'(1);
      if (pre_tick)
        div_cnt <= at_term ? '0 : div_cnt + DIV_W'(1);
    end
  end

  assign tick      = pre_tick && at_term;
  assign pe_enable = loaded;
  assign rd_data   = {loaded, pre_sel, div_val};

  a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    pe_enable |=> pe_enable);
  a_r3_set_any_data: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[DIV_W+1]) |=> rd_data[DIV_W+1]);
  a_r2_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));
  a_r7_write_restart: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (div_cnt == '0 && pre_cnt == '0));
  a_r5_wrap_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en) |=> (div_cnt == '0));
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    div_cnt <= div_val);
  a_r6_pre_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_sel |-> (pre_cnt == '0));
endmodule

// File: tb/flash_tick_divider_tb_top.sv
`timescale 1ns/1ps
module flash_tick_divider_tb_top;
  localparam real CLK_NS = 4.0;
  localparam int  NVEC   = 9;
  localparam logic [15:0] VEC [NVEC] = '{
    16'h27_A7, 16'h04_84, 16'h00_80, 16'h45_C5, 16'hC3_C3,
    16'h3F_BF, 16'h7F_FF, 16'h01_81, 16'h40_C0
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic tick, pe_enable;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  flash_tick_divider dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .tick(tick), .pe_enable(pe_enable)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic measure(input logic [7:0] d);
    int first = -1, second = -1, width_ok = 1, n, per, exp_first;
    n = d[5:0];
    per = d[6] ? 8*(n+1) : n+1;
    exp_first = per - 1;
    for (int k = 0; k < 1200; k++) begin
      if (tick) begin
        if (first < 0) first = k;
        else if (second < 0) second = k;
      end
      if (per > 1 && first >= 0 && k == first+1 && tick) width_ok = 0;
      if (second >= 0) break;
      @(negedge clk);
    end
    chk(first == exp_first, "R7 first tick", first, exp_first);
    if (d[6]) chk(second-first == per, "R6 prescaled period", second-first, per);
    else      chk(second-first == per, "R5 period", second-first, per);
    if (per > 1) chk(width_ok == 1, "R9 tick width", width_ok, 1);
  endtask

  initial begin
    #(CLK_NS*200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_data == 8'h00, "R1 reset readback", rd_data, 0);
    chk(pe_enable == 1'b0, "R4 locked after reset", pe_enable, 0);
    for (int k = 0; k < 4; k++) begin
      chk(tick == 1'b1, "R8 default tick every cycle", tick, 1);
      @(negedge clk);
    end

    do_write(8'h00);
    chk(rd_data == 8'h80, "R3 zero write sets flag", rd_data, 8'h80);
    chk(pe_enable == 1'b1, "R4 enabled after write", pe_enable, 1);
    measure(8'h00);

    for (int i = 0; i < NVEC; i++) begin
      do_write(VEC[i][15:8]);
      chk(rd_data == VEC[i][7:0], "R2 readback", rd_data, VEC[i][7:0]);
      chk(pe_enable == 1'b1, "R3 flag stays set", pe_enable, 1);
      measure(VEC[i][15:8]);
    end

    do_write(8'h05);
    repeat (3) @(negedge clk);
    do_write(8'h05);
    measure(8'h05);

    do_write(8'h42);
    repeat (5) @(negedge clk);
    do_write(8'h42);
    measure(8'h42);

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(rd_data == 8'h00, "R1 second reset readback", rd_data, 0);
    chk(pe_enable == 1'b0, "R3 flag cleared by reset", pe_enable, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule